// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block turns the status flags of a 16550-style serial port into one interrupt request line and an 8-bit identification value. The identification value tells software which condition to service first. It holds the 4-bit interrupt enable register. It also holds a hidden "transmitter empty" pending flag, which reads and writes of the register file set or clear. The FIFOs, the shift registers, the baud generator and the address decoding all live elsewhere. They reach this block only as level flags, one-cycle event strobes and access strobes.

Five sources compete, and exactly one is reported at a time. Each source needs its own enable bit. The received-data source is further gated by the FIFO trigger level whenever the FIFOs are on. The character-timeout source shares the received-data enable bit. The identification code and the interrupt line are decoded in the same cycle from the registered enable bits, the registered pending flag and the incoming status flags.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, the enable register reads 0, the transmit pending flag is clear, the low nibble of the identification value is 0x1 (nothing pending) and `irq` is 0.
- R2: When several sources are active, exactly one is reported. The order from highest to lowest is: line error, then character timeout, then received data, then transmitter empty, then modem status.
- R3: The low nibble of the identification value is 0x6 for line error, 0xC for timeout, 0x4 for received data, 0x2 for transmitter empty, 0x0 for modem status and 0x1 for none. Bits 5:4 are always 0.
- R4: The line-error source is active when enable bit 2 is set and any of `line_status` bits 4:1 is set (overrun, parity, framing, break).
- R5: The timeout source is active only when `rx_timeout` is high and enable bit 0 is set.
- R6: The received-data source is active when enable bit 0 and `line_status` bit 0 (data ready) are both set, and either `fifo_en` is low or `rx_count` >= `rx_trig`.
- R7: The transmitter-empty source is active when enable bit 1 and the pending flag are both set. The modem source is active when enable bit 3 is set and any bit of `msr_delta` is set.
- R8: Bits 7:6 of the identification value are 11 while `fifo_en` is high and 00 otherwise.
- R9: `irq` is high exactly when the reported code is not 0x1.
- R10: An `iid_rd` in a cycle whose reported code is 0x2 clears the pending flag from the next cycle on. An `iid_rd` in a cycle that reports any other code leaves the flag unchanged.
- R11: An `ier_wr` stores `ier_wdata[3:0]`, and bits 7:4 are ignored. If `line_status` bit 5 (holding register empty) is high during that write, the pending flag is set.
- R12: `tx_empty_evt` sets the pending flag and `tx_load` clears it. When a set and a clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 8 | Write data for the enable register |
| iid_rd | input | 1 | Read strobe for the identification register |
| tx_empty_evt | input | 1 | One-cycle pulse: holding register has just become empty |
| tx_load | input | 1 | One-cycle pulse: software has loaded a byte for transmission |
| line_status | input | 8 | Line status: bit0 data ready, bits4:1 errors, bit5 holding empty |
| fifo_en | input | 1 | FIFOs enabled |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| rx_timeout | input | 1 | Character timeout pending |
| msr_delta | input | DELTA_W | Modem status change bits |
| ier_q | output | 4 | Current enable register |
| iid | output | 8 | Identification value |
| irq | output | 1 | Interrupt request |

## Verification
The identification value and `irq` follow the status inputs in the same cycle. A write to the enable register, and any change of the pending flag, shows on the outputs only in the cycle after the strobe. The bench changes its inputs on the falling edge and lets them settle for 2 ns. It then compares every output with a behavioural model before the next rising edge. The model's enable and pending state moves forward only at that rising edge, so a strobe applied in one window is checked for its effect in the next window.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int IER_W = 4;

    // enable register bit positions
    localparam int ENA_RXD   = 0;
    localparam int ENA_TXE   = 1;
    localparam int ENA_LSTAT = 2;
    localparam int ENA_MODEM = 3;

    // line status bit positions / masks
    localparam int          LS_READY   = 0;
    localparam int          LS_HOLD_MT = 5;
    localparam logic [7:0]  LS_ERR_MASK = 8'h1E;

    typedef enum logic [3:0] {
        IID_MODEM = 4'h0,
        IID_NONE  = 4'h1,
        IID_TXE   = 4'h2,
        IID_RXD   = 4'h4,
        IID_LSTAT = 4'h6,
        IID_TMO   = 4'hC
    } iid_code_e;

    typedef struct packed {
        logic lstat;
        logic tmo;
        logic rxd;
        logic txe;
        logic modem;
    } src_req_t;

    function automatic iid_code_e pick_code(input src_req_t r);
        iid_code_e c;
        if (r.lstat)      c = IID_LSTAT;
        else if (r.tmo)   c = IID_TMO;
        else if (r.rxd)   c = IID_RXD;
        else if (r.txe)   c = IID_TXE;
        else if (r.modem) c = IID_MODEM;
        else              c = IID_NONE;
        return c;
    endfunction

    function automatic logic [7:0] pack_iid(input logic fifo_on, input iid_code_e c);
        return {fifo_on, fifo_on, 2'b00, c};
    endfunction

endpackage

// File: rtl/uart_irq_ier_reg.sv
module uart_irq_ier_reg
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [7:0]       wdata,
    output logic [IER_W-1:0] ier_q
);
    always_ff @(posedge clk) begin
        if (rst)
            ier_q <= '0;
        else if (wr)
            ier_q <= wdata[IER_W-1:0];
    end
endmodule

// File: rtl/uart_irq_txe_pend.sv
module uart_irq_txe_pend (
    input  logic clk,
    input  logic rst,
    input  logic empty_evt,
    input  logic load_evt,
    input  logic ier_wr,
    input  logic hold_empty,
    input  logic iid_rd,
    input  logic code_is_txe,
    output logic pend_q
);
    logic set_req;
    logic clr_req;

    always_comb begin
        set_req = empty_evt | (ier_wr & hold_empty);
        clr_req = load_evt | (iid_rd & code_is_txe);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (set_req)
            pend_q <= 1'b1;
        else if (clr_req)
            pend_q <= 1'b0;
    end
endmodule

// File: rtl/uart_irq_src_qual.sv
module uart_irq_src_qual
    import uart_irq_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int DELTA_W = 4
) (
    input  logic [IER_W-1:0]   ier,
    input  logic [7:0]         line_status,
    input  logic               fifo_en,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   rx_trig,
    input  logic               rx_timeout,
    input  logic               txe_pend,
    input  logic [DELTA_W-1:0] msr_delta,
    output src_req_t           req
);
    logic level_ok;

    always_comb begin
        level_ok  = !fifo_en || (rx_count >= rx_trig);
        req.lstat = ier[ENA_LSTAT] && |(line_status & LS_ERR_MASK);
        req.tmo   = ier[ENA_RXD] && rx_timeout;
        req.rxd   = ier[ENA_RXD] && line_status[LS_READY] && level_ok;
        req.txe   = ier[ENA_TXE] && txe_pend;
        req.modem = ier[ENA_MODEM] && |msr_delta;
    end
endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
    import uart_irq_pkg::*;
(
    input  src_req_t   req,
    input  logic       fifo_en,
    output iid_code_e  code,
    output logic [7:0] iid,
    output logic       irq
);
    always_comb begin
        code = pick_code(req);
        iid  = pack_iid(fifo_en, code);
        irq  = (code != IID_NONE);
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int DELTA_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ier_wr,
    input  logic [7:0]         ier_wdata,
    input  logic               iid_rd,
    input  logic               tx_empty_evt,
    input  logic               tx_load,
    input  logic [7:0]         line_status,
    input  logic               fifo_en,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   rx_trig,
    input  logic               rx_timeout,
    input  logic [DELTA_W-1:0] msr_delta,
    output logic [IER_W-1:0]   ier_q,
    output logic [7:0]         iid,
    output logic               irq
);
    logic      txe_pend;
    src_req_t  req;
    iid_code_e code;

    uart_irq_ier_reg u_ier (
        .clk   (clk),
        .rst   (rst),
        .wr    (ier_wr),
        .wdata (ier_wdata),
        .ier_q (ier_q)
    );

    uart_irq_txe_pend u_pend (
        .clk         (clk),
        .rst         (rst),
        .empty_evt   (tx_empty_evt),
        .load_evt    (tx_load),
        .ier_wr      (ier_wr),
        .hold_empty  (line_status[LS_HOLD_MT]),
        .iid_rd      (iid_rd),
        .code_is_txe (code == IID_TXE),
        .pend_q      (txe_pend)
    );

    uart_irq_src_qual #(.CNT_W(CNT_W), .DELTA_W(DELTA_W)) u_qual (
        .ier         (ier_q),
        .line_status (line_status),
        .fifo_en     (fifo_en),
        .rx_count    (rx_count),
        .rx_trig     (rx_trig),
        .rx_timeout  (rx_timeout),
        .txe_pend    (txe_pend),
        .msr_delta   (msr_delta),
        .req         (req)
    );

    uart_irq_prio_enc u_enc (
        .req     (req),
        .fifo_en (fifo_en),
        .code    (code),
        .iid     (iid),
        .irq     (irq)
    );
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int CNT_W   = 5,
    parameter int DELTA_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               ier_wr,
    input logic [7:0]         ier_wdata,
    input logic               iid_rd,
    input logic               tx_empty_evt,
    input logic               tx_load,
    input logic [7:0]         line_status,
    input logic               fifo_en,
    input logic [CNT_W-1:0]   rx_count,
    input logic [CNT_W-1:0]   rx_trig,
    input logic               rx_timeout,
    input logic [DELTA_W-1:0] msr_delta,
    input logic [3:0]         ier_q,
    input logic [7:0]         iid,
    input logic               irq
);
    AST_IER_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        ier_wr |=> ier_q == $past(ier_wdata[3:0])); // R11

    AST_IER_REARM: assert property (@(posedge clk) disable iff (rst)
        (ier_wr && line_status[5] && ier_wdata[1]) |=> (ier_wr || irq)); // R11

    AST_IID_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (iid_rd && iid[3:0] == 4'h2 && !tx_empty_evt && !ier_wr) |=> iid[3:0] != 4'h2); // R10

    AST_LINE_ERR_TOP: assert property (@(posedge clk) disable iff (rst)
        (ier_q[2] && (line_status[4:1] != 4'b0)) |-> iid[3:0] == 4'h6); // R2

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ier_q == 4'h0) |-> !irq); // R9

    AST_TMO_NEEDS_RXEN: assert property (@(posedge clk) disable iff (rst)
        (iid[3:0] == 4'hC) |-> ier_q[0]); // R5

    AST_EMPTY_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        tx_empty_evt |=> (!ier_q[1] || irq)); // R12
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W), .DELTA_W(DELTA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ier_wr       (ier_wr),
    .ier_wdata    (ier_wdata),
    .iid_rd       (iid_rd),
    .tx_empty_evt (tx_empty_evt),
    .tx_load      (tx_load),
    .line_status  (line_status),
    .fifo_en      (fifo_en),
    .rx_count     (rx_count),
    .rx_trig      (rx_trig),
    .rx_timeout   (rx_timeout),
    .msr_delta    (msr_delta),
    .ier_q        (ier_q),
    .iid          (iid),
    .irq          (irq)
);

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;
    localparam int CNT_W   = 5;
    localparam int DELTA_W = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               ier_wr = 1'b0;
    logic [7:0]         ier_wdata = 8'h00;
    logic               iid_rd = 1'b0;
    logic               tx_empty_evt = 1'b0;
    logic               tx_load = 1'b0;
    logic [7:0]         line_status = 8'h00;
    logic               fifo_en = 1'b0;
    logic [CNT_W-1:0]   rx_count = '0;
    logic [CNT_W-1:0]   rx_trig = 5'd1;
    logic               rx_timeout = 1'b0;
    logic [DELTA_W-1:0] msr_delta = '0;
    logic [3:0]         ier_q;
    logic [7:0]         iid;
    logic               irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    int m_ier  = 0;
    int m_pend = 0;

    always #10 clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W), .DELTA_W(DELTA_W)) uut (
        .clk(clk), .rst(rst), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .iid_rd(iid_rd), .tx_empty_evt(tx_empty_evt), .tx_load(tx_load),
        .line_status(line_status), .fifo_en(fifo_en), .rx_count(rx_count),
        .rx_trig(rx_trig), .rx_timeout(rx_timeout), .msr_delta(msr_delta),
        .ier_q(ier_q), .iid(iid), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected low code from the requirement list
    function automatic int exp_code();
        int lerr = ((m_ier & 4) != 0) && (line_status[4:1] != 0);
        int tmo  = ((m_ier & 1) != 0) && rx_timeout;
        int rxd  = ((m_ier & 1) != 0) && line_status[0] &&
                   (!fifo_en || (int'(rx_count) >= int'(rx_trig)));
        int txe  = ((m_ier & 2) != 0) && (m_pend != 0);
        int mdm  = ((m_ier & 8) != 0) && (msr_delta != 0);
        if (lerr) return 6;
        if (tmo)  return 12;
        if (rxd)  return 4;
        if (txe)  return 2;
        if (mdm)  return 0;
        return 1;
    endfunction

    function automatic string code_tag(input int c);
        case (c)
            6: return "R4";
            12: return "R5";
            4: return "R6";
            2, 0: return "R7";
            default: return "R3";
        endcase
    endfunction

    // compare at the current (settled) time, then advance model over one edge
    task automatic tick();
        int c = exp_code();
        int nxt_pend = m_pend;
        check(code_tag(c), int'(iid[3:0]), c);
        check("R8", int'(iid[7:4]), fifo_en ? 12 : 0);
        check("R9", int'(irq), (c != 1) ? 1 : 0);
        check("R11", int'(ier_q), m_ier);
        if (tx_load || (iid_rd && c == 2)) nxt_pend = 0;
        if (tx_empty_evt || (ier_wr && line_status[5])) nxt_pend = 1;
        @(posedge clk);
        if (ier_wr) m_ier = int'(ier_wdata[3:0]);
        m_pend = nxt_pend;
        @(negedge clk);
    endtask

    task automatic idle_strobes();
        ier_wr = 0; iid_rd = 0; tx_empty_evt = 0; tx_load = 0;
    endtask

    task automatic settle();
        #2;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        settle();
        // R1 reset state
        check("R1", int'(iid), 8'h01);
        check("R1", int'(irq), 0);
        check("R1", int'(ier_q), 0);
        tick();

        // R11: upper write bits ignored, no rearm without holding-empty
        ier_wr = 1; ier_wdata = 8'hFF; settle(); tick(); idle_strobes();
        settle();
        check("R11", int'(ier_q), 4'hF);
        check("R11", int'(iid), 8'h01);
        tick();

        // R12: empty event sets pending
        tx_empty_evt = 1; settle(); tick(); idle_strobes(); settle();
        check("R12", int'(iid[3:0]), 2);
        tick();

        // R2: all sources, peel off one by one
        line_status = 8'h03; rx_timeout = 1; msr_delta = 4'h2; settle();
        check("R2", int'(iid[3:0]), 6); tick();
        line_status = 8'h01; settle();
        check("R2", int'(iid[3:0]), 12); tick();
        rx_timeout = 0; settle();
        check("R2", int'(iid[3:0]), 4); tick();
        line_status = 8'h00; settle();
        check("R2", int'(iid[3:0]), 2); tick();
        // R10: read while showing 0x2 clears pending
        iid_rd = 1; settle(); tick(); idle_strobes(); settle();
        check("R10", int'(iid[3:0]), 0); tick();
        msr_delta = 0; settle();
        check("R10", int'(iid[3:0]), 1); tick();

        // R5: timeout masked by rx-data enable
        ier_wr = 1; ier_wdata = 8'h0E; settle(); tick(); idle_strobes();
        rx_timeout = 1; settle();
        check("R5", int'(iid[3:0]), 1); tick();
        rx_timeout = 0;

        // R6: trigger level with FIFOs on
        ier_wr = 1; ier_wdata = 8'h01; settle(); tick(); idle_strobes();
        fifo_en = 1; rx_trig = 5'd4; rx_count = 5'd3; line_status = 8'h01; settle();
        check("R6", int'(iid), 8'hC1); tick();
        rx_count = 5'd4; settle();
        check("R6", int'(iid), 8'hC4); tick();
        fifo_en = 0; rx_count = 0; settle();
        check("R6", int'(iid), 8'h04); tick();

        // R10: read while showing 0x4 keeps transmit pending
        ier_wr = 1; ier_wdata = 8'h03; settle(); tick(); idle_strobes();
        tx_empty_evt = 1; settle(); tick(); idle_strobes();
        iid_rd = 1; settle();
        check("R10", int'(iid[3:0]), 4); tick(); idle_strobes();
        line_status = 8'h00; settle();
        check("R10", int'(iid[3:0]), 2); tick();

        // R12: set wins over clear
        tx_load = 1; tx_empty_evt = 1; settle(); tick(); idle_strobes(); settle();
        check("R12", int'(iid[3:0]), 2); tick();
        tx_load = 1; settle(); tick(); idle_strobes(); settle();
        check("R12", int'(iid[3:0]), 1); tick();

        // R11: enable write with holding register empty re-arms
        line_status = 8'h20; ier_wr = 1; ier_wdata = 8'hA2; settle(); tick(); idle_strobes();
        settle();
        check("R11", int'(ier_q), 2);
        check("R11", int'(iid[3:0]), 2);
        tick();

        // random traffic, compared every cycle
        for (int i = 0; i < 4000; i++) begin
            ier_wr       = ($urandom_range(0, 9) == 0);
            ier_wdata    = 8'($urandom);
            iid_rd       = ($urandom_range(0, 3) == 0);
            tx_empty_evt = ($urandom_range(0, 5) == 0);
            tx_load      = ($urandom_range(0, 5) == 0);
            line_status  = 8'($urandom) & (($urandom_range(0, 2) == 0) ? 8'hFF : 8'hE1);
            fifo_en      = 1'($urandom);
            rx_count     = 5'($urandom_range(0, 16));
            case ($urandom_range(0, 3))
                0: rx_trig = 5'd1;
                1: rx_trig = 5'd4;
                2: rx_trig = 5'd8;
                default: rx_trig = 5'd14;
            endcase
            rx_timeout   = ($urandom_range(0, 4) == 0);
            msr_delta    = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'h0;
            settle();
            tick();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule